// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides its input clock by a programmable 16-bit time constant and produces a square-wave bit clock for a serial channel. A host writes the time constant one byte at a time and sets an enable bit. While the generator runs, a down counter starts from the time constant and counts to zero. Each time the counter reaches zero, the output flips and the counter is reloaded. Every output half-period lasts exactly the time constant plus two input clock cycles. The output frequency is therefore the input clock divided by 2 × (TC + 2). A time constant of zero gives the fastest rate, a toggle every two cycles.

The block also reports a zero-count status flag and a one-cycle interrupt request. Both are gated by an interrupt-enable bit. Reset forces the status flag active. Clearing the enable bit freezes the counter and the output, so the host can load a new time constant safely. Setting the enable bit again restarts the generator from the high output level, using the current time constant. The divided clock is meant to feed a downstream x1/x16/x32/x64 sampling stage.

Top module: `baud_divider`

## Requirements
- R1: Write map, byte writes on `wr_en` at a clock edge: address 0 holds time-constant bits 7:0 and address 1 holds bits 15:8. At address 2, data bit 0 is the run enable and data bit 1 is the zero-count interrupt enable. Reset sets the time constant to 0 and clears both enable bits.
- R2: While reset is asserted, `baud_clk` is 1 and `zero_stat` is 1.
- R3: While enabled, `baud_clk` is a square wave in which every half-period lasts exactly TC + 2 clock cycles, for every TC from 0 up to a value using the high byte.
- R4: When the run enable changes from 0 to 1, `baud_clk` becomes 1 at that write's clock edge, and this first high phase lasts TC + 2 cycles.
- R5: While the run enable is 0, `baud_clk` holds its value. Writes to the time-constant registers do not change it.
- R6: With the interrupt enable set and the generator running, `zero_stat` is 1 for exactly 2 cycles of each half-period: the cycle the counter reaches zero and the reload cycle after it. With the interrupt enable clear, `zero_stat` stays 0.
- R7: `zero_irq` pulses for exactly one cycle per half-period, in the first cycle the counter is at zero. It pulses only while running with the interrupt enable set.
- R8: A time-constant write that commits at the reload edge does not affect that reload. The new value takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 = TC low byte, 1 = TC high byte, 2 = control |
| wr_data | input | 8 | Write data byte |
| baud_clk | output | 1 | Divided square-wave output |
| zero_stat | output | 1 | Zero-count status, gated by the interrupt enable, forced during reset |
| zero_irq | output | 1 | One-cycle pulse when the counter first reaches zero |

## Verification
The host's time-constant write and the counter's reload can land on the same clock edge. Whether the reload picks up the old or the new value decides the length of the following half-period. The bench provokes this case by watching for the `zero_irq` pulse and committing a low-byte write exactly one cycle later, at the reload edge. The rest of the current half must then follow the old constant (3), and the next full half must follow the new one (9). These two lengths are far enough apart that either wrong choice is visible. Sweeps over many small time constants, plus one constant using the high byte, judge the half-period lengths, the status cycles and the interrupt pulses against TC + 2, 2 and 1.

// File: rtl/baud_divider_pkg.sv
package baud_divider_pkg;
    // control register bit positions
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_ZIE_BIT = 1;
endpackage

// File: rtl/baud_divider_regs.sv
module baud_divider_regs
    import baud_divider_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    parameter int ADDR_W = 2,
    localparam int TC_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [TC_W-1:0]   tc,
    output logic              run,
    output logic              zie,
    output logic              start
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

    typedef struct packed {
        logic [TC_W-1:0] tc;
        logic            run;
        logic            zie;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_addr == ADDR_W'(i))
                    reg_d.tc[i*BYTE_W +: BYTE_W] = wr_data;
            end
            if (wr_addr == CTRL_ADDR) begin
                reg_d.run = wr_data[CTRL_RUN_BIT];
                reg_d.zie = wr_data[CTRL_ZIE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign tc    = reg_q.tc;
    assign run   = reg_q.run;
    assign zie   = reg_q.zie;
    assign start = reg_d.run & ~reg_q.run;

    // R1: a control write lands in the enable bits
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR) |=>
            (run == $past(wr_data[CTRL_RUN_BIT]) && zie == $past(wr_data[CTRL_ZIE_BIT])));

    // R1: a low byte write lands in the low time-constant bits
    assert_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> tc[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/baud_divider_counter.sv
module baud_divider_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TC_W-1:0] tc,
    input  logic            run,
    input  logic            zie,
    input  logic            start,
    output logic            baud_clk,
    output logic            zero_stat,
    output logic            zero_irq
);
    typedef struct packed {
        logic [TC_W-1:0] cnt;
        logic            reload;
        logic            out;
        logic            rst_hold;
    } cnt_t;

    cnt_t st_d, st_q;
    logic at_zero;
    logic hit;

    assign at_zero = (st_q.cnt == '0);
    assign hit     = run & ~st_q.reload & at_zero;

    always_comb begin
        st_d          = st_q;
        st_d.rst_hold = 1'b0;
        if (start) begin
            st_d.cnt    = tc;
            st_d.reload = 1'b1;
            st_d.out    = 1'b1;
        end else if (run) begin
            if (st_q.reload) begin
                st_d.cnt    = tc;
                st_d.reload = 1'b0;
            end else if (at_zero) begin
                st_d.out    = ~st_q.out;
                st_d.reload = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.reload   <= 1'b0;
            st_q.out      <= 1'b1;
            st_q.rst_hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_clk  = st_q.out;
    assign zero_stat = st_q.rst_hold | (zie & at_zero);
    assign zero_irq  = hit & zie;

    // R3: output only moves after a zero hit or a restart
    assert_toggle_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.out) |-> $past(hit || start));

    // R3: reload cycle loads the time constant
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.reload && run && !start) |=> st_q.cnt == $past(tc));

    // R5: frozen while disabled
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> ($stable(st_q.cnt) && $stable(st_q.out)));

    // R4: restart drives the output high
    assert_restart_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.out);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    parameter int ADDR_W = 2,
    localparam int TC_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_clk,
    output logic              zero_stat,
    output logic              zero_irq
);
    logic [TC_W-1:0] tc;
    logic            run;
    logic            zie;
    logic            start;

    baud_divider_regs #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tc      (tc),
        .run     (run),
        .zie     (zie),
        .start   (start)
    );

    baud_divider_counter #(
        .TC_W (TC_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc        (tc),
        .run       (run),
        .zie       (zie),
        .start     (start),
        .baud_clk  (baud_clk),
        .zero_stat (zero_stat),
        .zero_irq  (zero_irq)
    );

    // R7: an interrupt pulse always coincides with active status
    assert_irq_in_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_irq |-> zero_stat);

    // R7: no interrupt while stopped or masked
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !zie) |-> !zero_irq);

    // R6: status stays low once the interrupt enable has been clear for two cycles
    assert_status_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!zie && $past(!zie) && $past(rst_n)) |-> !zero_stat);
endmodule

// File: tb/baud_divider_test.sv
`timescale 1ns/1ps
module baud_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       baud_clk;
    logic       zero_stat;
    logic       zero_irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    baud_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .baud_clk  (baud_clk),
        .zero_stat (zero_stat),
        .zero_irq  (zero_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts negedges while baud_clk keeps its value at entry
    task automatic half(output int n, output int zs, output int iq);
        logic v;
        v = baud_clk; n = 0; zs = 0; iq = 0;
        while (baud_clk == v && n < 2000) begin
            n++;
            zs += int'(zero_stat);
            iq += int'(zero_irq);
            @(negedge clk);
        end
    endtask

    task automatic run_tc(input int t);
        int n, zs, iq;
        wr(2'd2, 8'h00);
        wr(2'd0, t[7:0]);
        wr(2'd1, t[15:8]);
        wr(2'd2, 8'h03);
        check("R4 restart level", int'(baud_clk), 1);
        half(n, zs, iq);
        check("R4 first high phase", n, t + 2);
        half(n, zs, iq);
        check("R3 low half", n, t + 2);
        check("R6 status cycles", zs, 2);
        check("R7 irq pulses", iq, 1);
        half(n, zs, iq);
        check("R3 high half", n, t + 2);
        check("R7 irq pulses high", iq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, zs, iq;
        logic held;
        #1;
        // R2: values during reset
        repeat (3) @(negedge clk);
        check("R2 reset out", int'(baud_clk), 1);
        check("R2 reset status", int'(zero_stat), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset disabled irq", int'(zero_irq), 0);

        // R3 sweep of small constants, including zero
        for (int t = 0; t <= 12; t++) run_tc(t);
        // R1 high byte position: 0x0100
        run_tc(256);

        // R5: disable during low phase, output held
        wr(2'd0, 8'd4); wr(2'd1, 8'd0); wr(2'd2, 8'h00); wr(2'd2, 8'h03);
        while (baud_clk != 1'b0) @(negedge clk);
        wr(2'd2, 8'h02);
        held = baud_clk;
        repeat (40) @(negedge clk);
        check("R5 held while disabled", int'(baud_clk), int'(held));
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd0);
        repeat (20) @(negedge clk);
        check("R5 tc write ignored", int'(baud_clk), int'(held));
        wr(2'd2, 8'h03);
        half(n, zs, iq);
        check("R4 restart after hold", n, 3);

        // R6/R7: interrupt enable clear
        wr(2'd2, 8'h00); wr(2'd0, 8'd2); wr(2'd2, 8'h01);
        half(n, zs, iq);
        half(n, zs, iq);
        check("R6 masked status", zs, 0);
        check("R7 masked irq", iq, 0);
        check("R3 masked half", n, 4);

        // R8: write commits on the reload edge
        wr(2'd2, 8'h00); wr(2'd0, 8'd3); wr(2'd2, 8'h03);
        n = 0;
        while (zero_irq != 1'b1 && n < 2000) begin n++; @(negedge clk); end
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd9;
        @(negedge clk);
        wr_en = 1'b0;
        half(n, zs, iq);
        check("R8 current half old tc", n, 4);
        half(n, zs, iq);
        check("R8 next half new tc", n, 11);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule